// File: doc/BRIEF.md
# Configurable Synchronous Serial Port

This block is a full-duplex, three-wire synchronous serial port. It has one data output, one data input and one shift clock. As master it makes the shift clock from the module clock through a reload divider. As slave it takes the shift clock from an input pin, brings it into the module clock domain through two flops and detects its edges there. Every transfer moves the same number of bits in each direction. That number can be set from 2 to 16.

Software puts a word on `tx_data` and pulses `tx_wr` while the port is idle, and the transfer starts. Both buffers hold the frame right-aligned: bit 0 of the buffer is the lowest bit of the frame, whether the frame goes out LSB-first or MSB-first. The shift engine maps each serial bit to its buffer position, so no data is moved around at the edges of the block. The clock idle level and the clock phase control which edge drives data out and which edge samples data in. A one-cycle `done` pulse marks the end of a transfer.

Top module: `sync_serial_port`

## Requirements
- R1: While `rst` is high, at every clock edge `busy`, `done`, `rx_data` and `sck_out` are all cleared to 0.
- R2: A `tx_wr` pulse while `busy` is low starts a transfer, and `busy` reads 1 in the next cycle. A `tx_wr` pulse while `busy` is high is ignored: it does not change the frame in progress and it does not queue a second transfer.
- R3: In master mode each half-period of `sck_out` lasts `cfg_reload`+1 module clock cycles. The first edge comes `cfg_reload`+1 cycles after the start edge. While idle, `sck_out` rests at `cfg_cpol`, one cycle behind that input.
- R4: The frame length is `cfg_bits`, limited to the range 2 to 16: a value below 2 gives 2 bits and a value above 16 gives 16 bits. A master frame has exactly twice that many `sck_out` transitions. Bits of `tx_data` at and above the frame length never reach `sd_out`, and bits of `rx_data` at and above the frame length read 0.
- R5: With `cfg_msb_first`=0, serial bit k is taken from `tx_data[k]` and stored into `rx_data[k]`. With `cfg_msb_first`=1, serial bit k is taken from and stored into position length-1-k.
- R6: The leading edge is the first transition away from `cfg_cpol`. With `cfg_cpha`=0, `sd_out` holds the first bit from the cycle after the start, data is sampled on leading edges, and `sd_out` changes on trailing edges. With `cfg_cpha`=1, `sd_out` changes on leading edges and data is sampled on trailing edges.
- R7: `done` is high for exactly one cycle. In that cycle `busy` falls and `rx_data` takes the received frame. In master mode this is also the cycle in which `sck_out` makes its final transition back to idle. Outside that cycle `rx_data` holds its value.
- R8: In slave mode `sck_in` is sampled through a two-flop synchronizer, so the port reacts to each `sck_in` transition three module clock cycles later. `done` goes high three cycles after the final trailing transition, and the shift clock must run at no more than one quarter of the module clock.
- R9: The mode, bit order, polarity, phase, length and reload are captured when a transfer starts. Changing them while `busy` is high does not affect the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1 = master (generates the shift clock), 0 = slave |
| cfg_msb_first | input | 1 | Bit order: 1 = MSB-first, 0 = LSB-first |
| cfg_cpol | input | 1 | Idle level of the shift clock |
| cfg_cpha | input | 1 | 0 = sample on the leading edge, 1 = sample on the trailing edge |
| cfg_bits | input | 5 | Requested frame length in bits (limited to 2..16) |
| cfg_reload | input | 16 | Divider reload; half-period = reload+1 cycles |
| tx_wr | input | 1 | Write strobe for the transmit word; starts a transfer when idle |
| tx_data | input | 16 | Right-aligned transmit word |
| rx_data | output | 16 | Right-aligned received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sck_out | output | 1 | Shift clock output (master mode) |
| sck_in | input | 1 | Shift clock input (slave mode) |
| sd_out | output | 1 | Serial data output |
| sd_in | input | 1 | Serial data input |

## Verification
In master mode every result is tied to the start edge:
- `busy` is due one cycle after the write.
- The first `sck_out` transition is due `cfg_reload`+1 cycles after that, and each later transition the same number of cycles after the one before.
- `done`, the fall of `busy` and the new `rx_data` are all due in the cycle of the last transition.

The bench samples at falling clock edges and counts cycles from the first cycle in which `busy` is seen. It checks every gap against `cfg_reload`+1 and checks `done` at the exact transition that ends the frame. In slave mode the bench moves `sck_in` every six cycles. It reads `sd_out` just before each sampling transition it makes, which is three cycles or more after the port last changed that output. It then counts exactly three cycles from the final transition to `done`.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Which way the shift clock moved in this cycle
  typedef struct packed {
    logic valid;  // a transition happened this cycle
    logic lead;   // 1: the transition goes away from the idle level
  } ssp_edge_t;

  typedef enum logic {
    SSP_SLAVE  = 1'b0,
    SSP_MASTER = 1'b1
  } ssp_mode_t;

endpackage

// File: rtl/ssp_baud_gen.sv
module ssp_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] reload,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // Down-counter: gives one tick every reload+1 cycles while running
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || cnt_q == '0) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/ssp_sck_sync.sv
module ssp_sck_sync
  import ssp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sck_in,
  input  logic      idle_lvl,
  output ssp_edge_t edg
);

  logic meta_q, sync_q, last_q;

  // Two flops bring the pin into the clock domain; a third keeps the last value
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= sck_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_comb begin
    edg.valid = sync_q ^ last_q;
    edg.lead  = (last_q == idle_lvl);
  end

endmodule

// File: rtl/ssp_shift_engine.sv
module ssp_shift_engine
  import ssp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              active,
  input  ssp_edge_t         edg,
  input  logic              msb_first,
  input  logic              cpha,
  input  logic [CNT_W-1:0]  len,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              finish,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] txr_q, rxr_q, rx_nxt, len_mask;
  logic              ev_ok, sample_ev, shift_ev;
  logic [IDX_W-1:0]  pos_cur;

  // Turns a serial bit number into its right-aligned buffer position
  function automatic logic [IDX_W-1:0] map_pos(input logic msb, input logic [CNT_W-1:0] n,
                                               input logic [CNT_W-1:0] idx);
    logic [CNT_W-1:0] p;
    p = msb ? (n - idx - CNT_W'(1)) : idx;
    return p[IDX_W-1:0];
  endfunction

  // Mask of the bits inside the frame
  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign len_mask[g] = (CNT_W'(g) < len);
  end

  always_comb begin
    ev_ok     = active && edg.valid;
    sample_ev = ev_ok && (edg.lead ^ cpha);
    shift_ev  = ev_ok && !(edg.lead ^ cpha);
    pos_cur   = map_pos(msb_first, len, cnt_q);
    rx_nxt    = rxr_q;
    if (sample_ev) begin
      rx_nxt[pos_cur] = sd_in;
    end
    // The frame ends on the trailing edge that follows the last sample
    finish = ev_ok && !edg.lead &&
             (cpha ? ((cnt_q + CNT_W'(1)) == len) : (cnt_q == len));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      txr_q   <= '0;
      rxr_q   <= '0;
      sd_out  <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        rx_word <= rx_nxt & len_mask;
      end
      if (start) begin
        cnt_q <= '0;
        txr_q <= tx_word;
        rxr_q <= '0;
        if (!cpha) begin
          sd_out <= tx_word[map_pos(msb_first, len, '0)];
        end
      end else begin
        rxr_q <= rx_nxt;
        if (sample_ev) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (shift_ev && (cnt_q < len)) begin
          sd_out <= txr_q[pos_cur];
        end
      end
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_master,
  input  logic                         cfg_msb_first,
  input  logic                         cfg_cpol,
  input  logic                         cfg_cpha,
  input  logic [$clog2(DATA_W+1)-1:0]  cfg_bits,
  input  logic [DIV_W-1:0]             cfg_reload,
  input  logic                         tx_wr,
  input  logic [DATA_W-1:0]            tx_data,
  output logic [DATA_W-1:0]            rx_data,
  output logic                         busy,
  output logic                         done,
  output logic                         sck_out,
  input  logic                         sck_in,
  output logic                         sd_out,
  input  logic                         sd_in
);

  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int MIN_LEN = 2;

  logic             busy_q, msb_l, cpol_l, cpha_l, sck_q;
  ssp_mode_t        mode_l;
  logic [CNT_W-1:0] len_l, len_live, len_cur;
  logic [DIV_W-1:0] reload_l, reload_cur;
  logic             msb_cur, cpha_cur, start, tick, finish, run_div;
  ssp_edge_t        m_edge, s_edge, edg;

  // Clamp the requested length to the supported range
  always_comb begin
    if (cfg_bits < CNT_W'(MIN_LEN)) begin
      len_live = CNT_W'(MIN_LEN);
    end else if (cfg_bits > CNT_W'(DATA_W)) begin
      len_live = CNT_W'(DATA_W);
    end else begin
      len_live = cfg_bits;
    end
  end

  // Live settings apply in the start cycle; captured ones while busy
  always_comb begin
    start      = tx_wr && !busy_q;
    len_cur    = busy_q ? len_l    : len_live;
    msb_cur    = busy_q ? msb_l    : cfg_msb_first;
    cpha_cur   = busy_q ? cpha_l   : cfg_cpha;
    reload_cur = busy_q ? reload_l : cfg_reload;
    run_div    = busy_q && (mode_l == SSP_MASTER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      mode_l   <= SSP_SLAVE;
      msb_l    <= 1'b0;
      cpol_l   <= 1'b0;
      cpha_l   <= 1'b0;
      len_l    <= CNT_W'(MIN_LEN);
      reload_l <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      mode_l   <= ssp_mode_t'(cfg_master);
      msb_l    <= cfg_msb_first;
      cpol_l   <= cfg_cpol;
      cpha_l   <= cfg_cpha;
      len_l    <= len_live;
      reload_l <= cfg_reload;
    end else if (finish) begin
      busy_q <= 1'b0;
    end
  end

  // Master shift clock: rests at the idle level, toggles on every divider tick
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
    end else if (!busy_q) begin
      sck_q <= cfg_cpol;
    end else if (tick) begin
      sck_q <= ~sck_q;
    end
  end

  ssp_baud_gen #(.DIV_W(DIV_W)) baud_i (
    .clk    (clk),
    .rst    (rst),
    .run    (run_div),
    .reload (reload_cur),
    .tick   (tick)
  );

  ssp_sck_sync sync_i (
    .clk      (clk),
    .rst      (rst),
    .sck_in   (sck_in),
    .idle_lvl (cpol_l),
    .edg      (s_edge)
  );

  always_comb begin
    m_edge.valid = tick;
    m_edge.lead  = (sck_q == cpol_l);
    edg          = (mode_l == SSP_MASTER) ? m_edge : s_edge;
  end

  ssp_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) eng_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .active    (busy_q),
    .edg       (edg),
    .msb_first (msb_cur),
    .cpha      (cpha_cur),
    .len       (len_cur),
    .tx_word   (tx_data),
    .sd_in     (sd_in),
    .sd_out    (sd_out),
    .finish    (finish),
    .done      (done),
    .rx_word   (rx_data)
  );

  assign busy    = busy_q;
  assign sck_out = sck_q;

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_wr,
  input logic              busy,
  input logic              done,
  input logic              sck_out,
  input logic              cfg_cpol,
  input logic [DATA_W-1:0] rx_data,
  input logic [CNT_W-1:0]  len_l
);

  logic [DATA_W-1:0] above_mask;

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      above_mask[i] = (CNT_W'(i) >= len_l);
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && !busy) |=> busy); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R7

  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rx_data)); // R7

  AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> (sck_out == $past(cfg_cpol))); // R3

  AST_RX_ABOVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    done |-> ((rx_data & above_mask) == '0)); // R4

endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .tx_wr    (tx_wr),
  .busy     (busy),
  .done     (done),
  .sck_out  (sck_out),
  .cfg_cpol (cfg_cpol),
  .rx_data  (rx_data),
  .len_l    (len_l)
);

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;

  localparam int DW = 16;
  localparam int BW = 16;
  localparam int LW = $clog2(DW + 1);
  localparam int H  = 6;

  logic clk = 1'b0;
  logic rst;
  logic cfg_master, cfg_msb_first, cfg_cpol, cfg_cpha;
  logic [LW-1:0] cfg_bits;
  logic [BW-1:0] cfg_reload;
  logic tx_wr;
  logic [DW-1:0] tx_data, rx_data;
  logic busy, done, sck_out, sck_in, sd_out, sd_in;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  sync_serial_port #(.DATA_W(DW), .DIV_W(BW)) dut_i (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_msb_first(cfg_msb_first),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_bits(cfg_bits), .cfg_reload(cfg_reload),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_data(rx_data), .busy(busy), .done(done),
    .sck_out(sck_out), .sck_in(sck_in), .sd_out(sd_out), .sd_in(sd_in)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Serial bit k of a right-aligned word of n bits
  function automatic logic ser_bit(input logic [DW-1:0] d, input int n, input logic msb,
                                   input int k);
    return msb ? d[n-1-k] : d[k];
  endfunction

  function automatic logic [DW-1:0] ser_word(input logic [DW-1:0] d, input int n,
                                             input logic msb);
    logic [DW-1:0] w = '0;
    for (int k = 0; k < n; k++) w[k] = ser_bit(d, n, msb, k);
    return w;
  endfunction

  function automatic logic [DW-1:0] rx_expect(input logic [DW-1:0] spat, input int n,
                                              input logic msb);
    logic [DW-1:0] w = '0;
    for (int k = 0; k < n; k++) w[msb ? n-1-k : k] = spat[k];
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "done", {31'd0, done}, 0);
    chk("R1", "rx_data", {16'd0, rx_data}, 0);
    chk("R1", "sck_out", {31'd0, sck_out}, 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Master transfer, with the bench acting as the slave on the far side
  task automatic t_master(input string tag, input logic [LW-1:0] bits_req, input int n,
                          input logic msb, input logic cpol, input logic cpha,
                          input logic [BW-1:0] rl, input logic [DW-1:0] txd,
                          input logic [DW-1:0] spat, input bit meddle);
    logic [DW-1:0] cap = '0;
    int ncap = 0, trans = 0, last_t = 0, gap_bad = 0, early = 0;
    logic prev, lead;
    bit fin = 0;
    cfg_master = 1'b1; cfg_msb_first = msb; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_bits = bits_req; cfg_reload = rl; tx_data = txd; sd_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R3", {tag, " idle sck"}, {31'd0, sck_out}, {31'd0, cpol});
    if (!cpha) sd_in = spat[0];
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R2", {tag, " busy after write"}, {31'd0, busy}, 1);
    if (!cpha) chk("R6", {tag, " first bit early"}, {31'd0, sd_out},
                   {31'd0, ser_bit(txd, n, msb, 0)});
    prev = cpol;
    for (int t = 1; t <= 20000 && !fin; t++) begin
      @(negedge clk);
      if (sck_out !== prev) begin
        trans++;
        if (t - last_t != int'(rl) + 1) gap_bad++;
        last_t = t;
        lead = (prev === cpol);
        prev = sck_out;
        if (lead ^ cpha) begin
          if (ncap < n) cap[ncap] = sd_out;
          ncap++;
        end else if (ncap < n) begin
          sd_in = spat[ncap];
        end
        if (trans == 2 * n) begin
          fin = 1;
          chk("R7", {tag, " done at last edge"}, {31'd0, done}, 1);
          chk("R7", {tag, " busy low at last edge"}, {31'd0, busy}, 0);
        end
      end else if (done) begin
        early++;
      end
      // Disturb the inputs in the middle of the frame
      if (meddle && t == 2) begin
        tx_wr = 1'b1; tx_data = ~txd; cfg_msb_first = ~msb; cfg_cpha = ~cpha;
        cfg_bits = LW'(9); cfg_reload = rl + BW'(3);
      end else if (meddle && t == 3) begin
        tx_wr = 1'b0;
      end
    end
    chk("R3", {tag, " half-period gaps"}, gap_bad, 0);
    chk("R4", {tag, " transitions"}, trans, 2 * n);
    chk("R7", {tag, " no early done"}, early, 0);
    chk("R5", {tag, " serial bits out"}, {16'd0, cap}, {16'd0, ser_word(txd, n, msb)});
    chk("R5", {tag, " rx_data"}, {16'd0, rx_data}, {16'd0, rx_expect(spat, n, msb)});
    @(negedge clk);
    chk("R7", {tag, " done one cycle"}, {31'd0, done}, 0);
    if (meddle) begin
      @(negedge clk);
      chk("R2", {tag, " busy write not queued"}, {31'd0, busy}, 0);
      chk("R9", {tag, " settings held"}, ncap, n);
    end
  endtask

  // Slave transfer, with the bench acting as the master driving sck_in
  task automatic t_slave(input string tag, input int n, input logic msb, input logic cpol,
                         input logic cpha, input logic [DW-1:0] txd, input logic [DW-1:0] spat);
    logic [DW-1:0] cap = '0;
    int lat = 0;
    cfg_master = 1'b0; cfg_msb_first = msb; cfg_cpol = cpol; cfg_cpha = cpha;
    cfg_bits = LW'(n); cfg_reload = '0; tx_data = txd; sck_in = cpol; sd_in = 1'b0;
    repeat (4) @(negedge clk);
    if (!cpha) sd_in = spat[0];
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R2", {tag, " busy after write"}, {31'd0, busy}, 1);
    if (!cpha) chk("R6", {tag, " first bit early"}, {31'd0, sd_out},
                   {31'd0, ser_bit(txd, n, msb, 0)});
    repeat (H) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (!cpha) cap[k] = sd_out;
      sck_in = ~cpol;
      if (cpha) sd_in = spat[k];
      repeat (H) @(negedge clk);
      if (cpha) cap[k] = sd_out;
      sck_in = cpol;
      if (!cpha && k + 1 < n) sd_in = spat[k+1];
      if (k < n - 1) repeat (H) @(negedge clk);
    end
    for (int w = 1; w <= 8; w++) begin
      @(negedge clk);
      if (done) begin
        lat = w;
        break;
      end
    end
    chk("R8", {tag, " done latency"}, lat, 3);
    chk("R8", {tag, " busy cleared"}, {31'd0, busy}, 0);
    chk("R6", {tag, " serial bits out"}, {16'd0, cap}, {16'd0, ser_word(txd, n, msb)});
    chk("R5", {tag, " rx_data"}, {16'd0, rx_data}, {16'd0, rx_expect(spat, n, msb)});
    chk("R8", {tag, " sck_out idle"}, {31'd0, sck_out}, {31'd0, cpol});
    repeat (2) @(negedge clk);
  endtask

  initial begin
    cfg_master = 1'b1; cfg_msb_first = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    cfg_bits = LW'(8); cfg_reload = '0; tx_wr = 1'b0; tx_data = '0;
    sck_in = 1'b0; sd_in = 1'b0; rst = 1'b1;
    t_reset();                                                                           // R1
    t_master("m8_lsb_ph0", LW'(8), 8, 1'b0, 1'b0, 1'b0, BW'(1), 16'h00A5, 16'h0036, 0);   // R5 R6
    t_master("m8_msb_ph1", LW'(8), 8, 1'b1, 1'b0, 1'b1, BW'(0), 16'h00C3, 16'h005A, 0);   // R6
    t_master("m12_hi_ign", LW'(12), 12, 1'b1, 1'b1, 1'b0, BW'(2), 16'hF9E1, 16'h0B4D, 0); // R4
    t_master("m5_pol1_ph1", LW'(5), 5, 1'b0, 1'b1, 1'b1, BW'(4), 16'hFFF6, 16'h0013, 0);  // R3
    t_master("m_len_low", LW'(0), 2, 1'b1, 1'b0, 1'b0, BW'(0), 16'hFFFE, 16'h0001, 0);    // R4
    t_master("m_len_high", LW'(20), 16, 1'b0, 1'b0, 1'b1, BW'(1), 16'h8D3B, 16'hC671, 0); // R4
    t_master("m_meddle", LW'(10), 10, 1'b0, 1'b0, 1'b1, BW'(3), 16'h02D9, 16'h0366, 1);   // R2 R9
    t_slave("s8_msb_ph0", 8, 1'b1, 1'b0, 1'b0, 16'h0096, 16'h00E4);                       // R8
    t_slave("s11_lsb_ph1", 11, 1'b0, 1'b1, 1'b1, 16'h05B3, 16'h0729);                     // R8
    t_slave("s16_msb_ph0", 16, 1'b1, 1'b1, 1'b0, 16'hA50F, 16'h3CC9);                     // R8
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule